// File: doc/BRIEF.md
# Command-Word Keyed Watchdog Timer

This block is a watchdog peripheral for a simple register bus. It exposes two 32-bit registers: a control register that acts only on a small set of 16-bit magic command words, and a count register that shows a window onto a 20-bit down-counter. The counter steps down by one on each pulse of a slow timebase enable, nominally 90 kHz. Software sends command words to halt or restart the count, to clear the interrupt, to open and close write access to the count register, and to reload the counter to its full value in a single write.

When a running counter steps from one to zero, the block raises a sticky interrupt and a one-cycle reset request toward the system reset controller. The counter then stays at zero until software reloads it. A firmware-driven system restart is made by halting, unlocking, loading a count of one, relocking and restarting, which makes the counter expire a short, fixed number of ticks later.

Top module: `keyed_wdt`

## Requirements
- R1: After synchronous reset the counter is halted, count writes are locked, `irq` and `rst_req` are low, and the counter holds all ones, so the count register reads 0xFFFF.
- R2: The control register is at address 0x0 and always reads zero. The count register is at address 0x4 and reads counter bits [19:4] in bits [15:0], with zeros above. `rdata` follows `addr` with no clock delay.
- R3: Writing 0x3877 to control halts the counter and 0x4A4B restarts it. The counter drops by one on each clock where `tick` is high only while it is running.
- R4: Writing 0xAB00 to control unlocks the count register and 0xAB01 locks it again. A count-register write while locked changes nothing.
- R5: A count-register write while unlocked loads `wdata[15:0]` into counter bits [19:4] and sets bits [3:0] to 0xF on the next clock. This holds even while running, and the load overrides a tick in the same cycle.
- R6: Writing 0xDEAF to control sets the whole counter to all ones, whether the count register is locked or not.
- R7: When a running counter steps from 1 to 0, `irq` rises and `rst_req` is high for exactly one cycle, on the same clock edge. The counter then stays at zero.
- R8: `irq` is sticky and falls only after a control write of 0x7482. If an expiry happens in the same cycle as that write, the expiry wins and `irq` stays high.
- R9: A control write whose full 32-bit value is none of the six command words (this includes a valid code with any upper bit set) changes no state.
- R10: The sequence halt, unlock, load 0x0001, lock, restart makes the counter expire on exactly the 31st tick after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one pulse per counter step |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register byte address (0x0 control, 0x4 count) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Sticky expiry interrupt |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The hardest case to reach is a clear command that lands in the same cycle as the expiring tick. It can only come after 30 tick cycles that follow a count-of-one load, so the bench first drives the complete restart sequence to a known expiry point. It then issues the clear write and the final tick together in one cycle. The low four counter bits cannot be read at the ports. The bench infers them by counting exactly 15 and then 16 ticks after a load and watching the visible window change.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int CODE_W = 16;

    localparam logic [CODE_W-1:0] CODE_HALT   = 16'h3877;
    localparam logic [CODE_W-1:0] CODE_GO     = 16'h4A4B;
    localparam logic [CODE_W-1:0] CODE_CLRIRQ = 16'h7482;
    localparam logic [CODE_W-1:0] CODE_OPEN   = 16'hAB00;
    localparam logic [CODE_W-1:0] CODE_CLOSE  = 16'hAB01;
    localparam logic [CODE_W-1:0] CODE_FULL   = 16'hDEAF;

    localparam int CTRL_OFS  = 0;
    localparam int COUNT_OFS = 4;

    typedef struct packed {
        logic halt;
        logic go;
        logic clr_irq;
        logic open;
        logic close;
        logic load_full;
        logic load_cnt;
    } kwdt_cmd_t;

    function automatic logic kwdt_is_code(input logic [CODE_W-1:0] v);
        return (v == CODE_HALT) || (v == CODE_GO) || (v == CODE_CLRIRQ) ||
               (v == CODE_OPEN) || (v == CODE_CLOSE) || (v == CODE_FULL);
    endfunction

endpackage

// File: rtl/kwdt_decode.sv
module kwdt_decode
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int WIN_W  = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output kwdt_cmd_t         cmd,
    output logic [WIN_W-1:0]  load_val
);
    logic              wr_ctrl;
    logic              upper_zero;
    logic [CODE_W-1:0] code;

    always_comb begin
        wr_ctrl    = wr_en && (addr == ADDR_W'(CTRL_OFS));
        upper_zero = (wdata[DATA_W-1:CODE_W] == '0);
        code       = wdata[CODE_W-1:0];
        cmd.halt      = wr_ctrl && upper_zero && (code == CODE_HALT);
        cmd.go        = wr_ctrl && upper_zero && (code == CODE_GO);
        cmd.clr_irq   = wr_ctrl && upper_zero && (code == CODE_CLRIRQ);
        cmd.open      = wr_ctrl && upper_zero && (code == CODE_OPEN);
        cmd.close     = wr_ctrl && upper_zero && (code == CODE_CLOSE);
        cmd.load_full = wr_ctrl && upper_zero && (code == CODE_FULL);
        cmd.load_cnt  = wr_en && (addr == ADDR_W'(COUNT_OFS));
        load_val      = wdata[WIN_W-1:0];
    end
endmodule

// File: rtl/kwdt_lock.sv
module kwdt_lock (
    input  logic clk,
    input  logic rst,
    input  logic open,
    input  logic close,
    output logic locked
);
    always_ff @(posedge clk) begin
        if (rst)        locked <= 1'b1;
        else if (open)  locked <= 1'b0;
        else if (close) locked <= 1'b1;
    end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 20,
    parameter int WIN_W = 16,
    localparam int LSB_W = CNT_W - WIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    input  logic             go,
    input  logic             clr_irq,
    input  logic             load_full,
    input  logic             load_ok,
    input  logic [WIN_W-1:0] load_val,
    output logic [WIN_W-1:0] cnt_win,
    output logic             running,
    output logic             irq,
    output logic             rst_req
);
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic             expire;

    always_comb begin
        step    = running && tick && (cnt_q != '0);
        expire  = step && (cnt_q == CNT_W'(1));
        cnt_win = cnt_q[CNT_W-1:LSB_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            running <= 1'b0;
            irq     <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (halt)    running <= 1'b0;
            else if (go) running <= 1'b1;

            if (load_full)    cnt_q <= '1;
            else if (load_ok) cnt_q <= {load_val, {LSB_W{1'b1}}};
            else if (step)    cnt_q <= cnt_q - CNT_W'(1);

            if (expire && !load_full && !load_ok) begin
                irq     <= 1'b1;
                rst_req <= 1'b1;
            end else begin
                rst_req <= 1'b0;
                if (clr_irq) irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 20,
    localparam int WIN_W = CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    kwdt_cmd_t        cmd;
    logic [WIN_W-1:0] load_val;
    logic [WIN_W-1:0] cnt_win;
    logic             locked;
    logic             running;
    logic             load_ok;

    kwdt_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W)) u_decode (
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .cmd(cmd), .load_val(load_val)
    );

    kwdt_lock u_lock (
        .clk(clk), .rst(rst), .open(cmd.open), .close(cmd.close), .locked(locked)
    );

    assign load_ok = cmd.load_cnt && !locked;

    kwdt_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick),
        .halt(cmd.halt), .go(cmd.go), .clr_irq(cmd.clr_irq),
        .load_full(cmd.load_full), .load_ok(load_ok), .load_val(load_val),
        .cnt_win(cnt_win), .running(running), .irq(irq), .rst_req(rst_req)
    );

    always_comb begin
        if (addr == ADDR_W'(COUNT_OFS)) rdata = DATA_W'(cnt_win);
        else                             rdata = '0;
    end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int WIN_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [WIN_W-1:0]  cnt_win,
    input logic              running,
    input logic              locked,
    input logic              irq,
    input logic              rst_req
);
    logic wr_ctrl, wr_cnt, good_code, clr_wr;
    always_comb begin
        wr_ctrl   = wr_en && (addr == ADDR_W'(CTRL_OFS));
        wr_cnt    = wr_en && (addr == ADDR_W'(COUNT_OFS));
        good_code = (wdata[DATA_W-1:CODE_W] == '0) && kwdt_is_code(wdata[CODE_W-1:0]);
        clr_wr    = wr_ctrl && (wdata == DATA_W'(CODE_CLRIRQ));
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!running && locked && !irq && !rst_req));
    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!running && !wr_en) |=> $stable(cnt_win));
    // R4
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt && locked && !tick) |=> $stable(cnt_win));
    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    // R7
    req_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> irq);
    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_wr) |=> irq);
    // R9
    unknown_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !good_code) |=> ($stable(locked) && $stable(running)));
endmodule

bind keyed_wdt kwdt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt_win(cnt_win), .running(running), .locked(locked), .irq(irq), .rst_req(rst_req)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CTRL = 3'h0;
    localparam logic [2:0] A_CNT  = 3'h4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdt u_keyed_wdt (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit tk);
        wr_en = 1'b1; addr = a; wdata = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic expect_count(input logic [15:0] exp, input string tag);
        addr = A_CNT; #1;
        check(rdata == {16'h0, exp}, tag, rdata, {16'h0, exp});
    endtask

    task automatic t_reset;
        check(irq == 1'b0, "R1 irq low", irq, 0);
        check(rst_req == 1'b0, "R1 rst_req low", rst_req, 0);
        expect_count(16'hFFFF, "R1 count all ones");
        addr = A_CTRL; #1;
        check(rdata == 32'h0, "R2 control reads zero", rdata, 0);
    endtask

    task automatic t_halt_go;
        ticks(3);
        expect_count(16'hFFFF, "R3 halted after reset ignores ticks");
        wr(A_CTRL, 32'h4A4B, 0);
        ticks(16);
        expect_count(16'hFFFE, "R3 running counts 16 ticks");
        wr(A_CTRL, 32'h3877, 0);
        ticks(5);
        expect_count(16'hFFFE, "R3 halted holds");
    endtask

    task automatic t_lock_load;
        wr(A_CNT, 32'h1234, 0);
        expect_count(16'hFFFE, "R4 locked write ignored");
        wr(A_CTRL, 32'hAB00, 0);
        wr(A_CNT, 32'h0100, 0);
        expect_count(16'h0100, "R5 unlocked load");
        wr(A_CTRL, 32'hAB01, 0);
        wr(A_CNT, 32'h0200, 0);
        expect_count(16'h0100, "R4 relocked write ignored");
        wr(A_CTRL, 32'h4A4B, 0);
        ticks(15);
        expect_count(16'h0100, "R5 low bits 0xF after 15 ticks");
        ticks(1);
        expect_count(16'h00FF, "R5 window steps on 16th tick");
        wr(A_CTRL, 32'h3877, 0);
    endtask

    task automatic t_full;
        wr(A_CTRL, 32'hDEAF, 0);
        expect_count(16'hFFFF, "R6 full reload while locked");
    endtask

    task automatic t_unknown;
        wr(A_CTRL, 32'h0001_AB00, 0);
        wr(A_CNT, 32'h0055, 0);
        expect_count(16'hFFFF, "R9 code with upper bits does not unlock");
        wr(A_CTRL, 32'h0000_4A4C, 0);
        ticks(16);
        expect_count(16'hFFFF, "R9 near-miss code does not restart");
        wr(A_CTRL, 32'h1234, 0);
        check(irq == 1'b0, "R9 irq untouched", irq, 0);
    endtask

    task automatic t_restart;
        wr(A_CTRL, 32'h3877, 0);
        wr(A_CTRL, 32'hAB00, 0);
        wr(A_CNT, 32'h0001, 0);
        wr(A_CTRL, 32'hAB01, 0);
        wr(A_CTRL, 32'h4A4B, 0);
        ticks(30);
        check(irq == 1'b0, "R10 no expiry after 30 ticks", irq, 0);
        ticks(1);
        check(irq == 1'b1, "R10 expiry on 31st tick", irq, 1);
        check(rst_req == 1'b1, "R7 reset request asserted", rst_req, 1);
        @(negedge clk);
        check(rst_req == 1'b0, "R7 reset request one cycle", rst_req, 0);
        ticks(20);
        expect_count(16'h0000, "R7 counter holds at zero");
        check(rst_req == 1'b0, "R7 no second request", rst_req, 0);
    endtask

    task automatic t_irq;
        wr(A_CTRL, 32'hDEAF, 0);
        wr(A_CTRL, 32'hAB00, 0);
        check(irq == 1'b1, "R8 irq sticky across other commands", irq, 1);
        wr(A_CTRL, 32'h7482, 0);
        check(irq == 1'b0, "R8 clear drops irq", irq, 0);
        wr(A_CNT, 32'h0001, 0);
        ticks(30);
        wr(A_CTRL, 32'h7482, 1);
        check(irq == 1'b1, "R8 expiry beats same-cycle clear", irq, 1);
        check(rst_req == 1'b1, "R7 request on collided expiry", rst_req, 1);
        wr(A_CTRL, 32'h7482, 0);
        check(irq == 1'b0, "R8 later clear works", irq, 0);
    endtask

    task automatic t_load_running;
        wr(A_CNT, 32'h0050, 1);
        expect_count(16'h0050, "R5 load overrides same-cycle tick");
        ticks(15);
        expect_count(16'h0050, "R5 running load low bits 0xF");
        ticks(1);
        expect_count(16'h004F, "R5 running load steps");
        wr(A_CTRL, 32'hAB01, 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_halt_go();
        t_lock_load();
        t_full();
        t_unknown();
        t_restart();
        t_irq();
        t_load_running();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        finish_run();
    end
endmodule